// File: doc/BRIEF.md
# Core Regulator Power-Up Sequencer

This block is the digital sequencer that brings a processor core regulator from off to regulated output. Once the termination rail reports good and output enable is high, it ramps a digital reference code from zero to a fixed boot level of 1.1 V. It holds that level for a settling window so the processor's voltage identification (VID) code is stable, samples the code once, and ramps linearly to the level that code selects. After a further settling window it raises a ready flag. The reference is an unsigned code with a 6.25 mV LSB, so code 176 is 1.1 V and code 256 is 1.6 V.

All timing is counted in microsecond ticks supplied by the chip's timebase. The lengths of the two ramps come from configuration inputs and are clamped to legal ranges. The boot hold and the ready delay are fixed parameters of 50 ticks each. Losing output enable or termination power-good at any point drops ready at once and sends the sequencer back to off.

Top module: `vrseq_ctrl`

## Requirements
- R1: In reset, and whenever output enable or termination power-good is low, `ref_code_o` is 0 and `ready_o` is 0.
- R2: In the cycle where both `out_en_i` and `vtt_pgood_i` are first seen high, a boot ramp of N ticks starts from 0. After k ticks of that ramp the reference equals floor(k*176/N), so it first reaches 176 (1.1 V) on tick N. A tick that arrives in the start cycle does not count.
- R3: The boot ramp length N is `boot_ramp_us_i` clamped to the range 50 to 10000 ticks.
- R4: The reference holds at 176 for 50 ticks after the boot ramp ends. The VID bus is sampled once, in the cycle after the 50th hold tick. Values on the bus before or after that cycle have no effect.
- R5: With the table select latched low, the target is 256 - vid[6:0] for vid[6:0] from 0 to 123, and 0 for vid[6:0] of 124 or more. vid[7] is ignored.
- R6: With the table select latched high, the target is 257 - vid for vid from 1 to 253, and 0 for vid of 0, 254 or 255. The reference never exceeds 256.
- R7: `tbl_sel_i` is latched in the cycle the boot ramp starts. Later changes have no effect on that sequence.
- R8: The final ramp runs from 176 to the target over M ticks. After k ticks the reference is 176 + floor(k*(target-176)/M) when rising, or 176 - floor(k*(176-target)/M) when falling. M is `final_ramp_us_i` clamped to 1 to 2500 ticks.
- R9: `ready_o` rises in the cycle after the 50th tick that follows the end of the final ramp. From then on the reference stays constant.
- R10: Dropping `out_en_i` or `vtt_pgood_i` clears `ready_o` in the same cycle and returns the reference to 0 at the next clock edge. A later enable restarts the whole sequence from 0.
- R11: While enable and power-good stay high, the reference changes only at clock edges that carry a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse once per microsecond |
| vtt_pgood_i | input | 1 | Termination rail power good |
| out_en_i | input | 1 | Regulator output enable |
| tbl_sel_i | input | 1 | VID table select: 0 = 7-bit extended table, 1 = 8-bit linear table |
| vid_i | input | 8 | Voltage identification code from the processor |
| boot_ramp_us_i | input | 14 | Requested boot ramp length in ticks |
| final_ramp_us_i | input | 14 | Requested final ramp length in ticks |
| ref_code_o | output | 9 | Reference code, 6.25 mV per LSB |
| ready_o | output | 1 | Regulator ready |

## Verification
The assertions assume that tick pulses last one clock and are spaced at least two clocks apart. Under that spacing no tick lands on the clock where one phase hands over to the next, so every tick is counted by exactly one phase. The stimulus raises the tick for one clock in every four. It changes enable, power-good, table select and VID only at falling edges. Every ramp length is chosen so that a whole sequence is short, and each sequence gets a fresh expected profile from the scoreboard.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_BOOT_RAMP,
    ST_BOOT_HOLD,
    ST_FINAL_RAMP,
    ST_READY_WAIT,
    ST_READY
  } seq_state_e;

  typedef enum logic {
    TBL_EXT7 = 1'b0,
    TBL_LIN8 = 1'b1
  } vid_tbl_e;
endpackage

// File: rtl/vrseq_vid_decode.sv
module vrseq_vid_decode
  import vrseq_pkg::*;
#(
  parameter int unsigned VID_W     = 8,
  parameter int unsigned REF_W     = 9,
  parameter int unsigned FULL_CODE = 256,
  parameter int unsigned EXT_LAST  = 123,
  parameter int unsigned LIN_LAST  = 253
) (
  input  vid_tbl_e               tbl_i,
  input  logic [VID_W-1:0]       vid_i,
  output logic [REF_W-1:0]       code_o
);
  logic [VID_W-2:0] ext_idx;

  always_comb begin
    ext_idx = vid_i[VID_W-2:0];
    code_o  = '0;
    if (tbl_i == TBL_EXT7) begin
      if (32'(ext_idx) <= EXT_LAST) code_o = REF_W'(FULL_CODE - 32'(ext_idx));
    end else begin
      if (vid_i != '0 && 32'(vid_i) <= LIN_LAST) code_o = REF_W'(FULL_CODE + 1 - 32'(vid_i));
    end
  end
endmodule

// File: rtl/vrseq_tick_timer.sv
module vrseq_tick_timer #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (load_i)               cnt_q <= len_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/vrseq_ramp.sv
module vrseq_ramp #(
  parameter int unsigned REF_W = 9,
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [REF_W-1:0] from_i,
  input  logic [REF_W-1:0] to_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic [REF_W-1:0] ref_o,
  output logic             done_o
);
  logic [REF_W-1:0] ref_q, quo_q, quo_d, mag_d, step;
  logic [LEN_W-1:0] cnt_q, len_q, rem_q, acc_q, rem_d, len_nz, acc_nx;
  logic [LEN_W:0]   acc_sum;
  logic             up_q, up_d, carry;

  // Split the total move into a whole per-tick step and a remainder spread Bresenham-style
  always_comb begin
    len_nz = (len_i == '0) ? LEN_W'(1) : len_i;
    up_d   = (to_i >= from_i);
    mag_d  = up_d ? (to_i - from_i) : (from_i - to_i);
    quo_d  = REF_W'(32'(mag_d) / 32'(len_nz));
    rem_d  = LEN_W'(32'(mag_d) % 32'(len_nz));
  end

  always_comb begin
    acc_sum = {1'b0, acc_q} + {1'b0, rem_q};
    carry   = (acc_sum >= {1'b0, len_q});
    acc_nx  = carry ? LEN_W'(acc_sum - {1'b0, len_q}) : acc_sum[LEN_W-1:0];
    step    = quo_q + {{(REF_W-1){1'b0}}, carry};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      cnt_q <= '0;
      len_q <= LEN_W'(1);
      quo_q <= '0;
      rem_q <= '0;
      acc_q <= '0;
      up_q  <= 1'b1;
    end else if (clear_i) begin
      ref_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (start_i) begin
      ref_q <= from_i;
      cnt_q <= len_nz;
      len_q <= len_nz;
      quo_q <= quo_d;
      rem_q <= rem_d;
      acc_q <= '0;
      up_q  <= up_d;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      acc_q <= acc_nx;
      ref_q <= up_q ? (ref_q + step) : (ref_q - step);
    end
  end

  assign ref_o  = ref_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/vrseq_ctrl.sv
module vrseq_ctrl
  import vrseq_pkg::*;
#(
  parameter int unsigned REF_W         = 9,
  parameter int unsigned VID_W         = 8,
  parameter int unsigned LEN_W         = 14,
  parameter int unsigned LSB_UV        = 6250,
  parameter int unsigned BOOT_UV       = 1100000,
  parameter int unsigned TOP_UV        = 1600000,
  parameter int unsigned VID_WAIT_US   = 50,
  parameter int unsigned READY_DLY_US  = 50,
  parameter int unsigned BOOT_LEN_MIN  = 50,
  parameter int unsigned BOOT_LEN_MAX  = 10000,
  parameter int unsigned FINAL_LEN_MIN = 1,
  parameter int unsigned FINAL_LEN_MAX = 2500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_us_i,
  input  logic             vtt_pgood_i,
  input  logic             out_en_i,
  input  logic             tbl_sel_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [LEN_W-1:0] boot_ramp_us_i,
  input  logic [LEN_W-1:0] final_ramp_us_i,
  output logic [REF_W-1:0] ref_code_o,
  output logic             ready_o
);
  localparam logic [REF_W-1:0] BOOT_CODE = REF_W'(BOOT_UV / LSB_UV);
  localparam int unsigned      FULL_CODE = TOP_UV / LSB_UV;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v,
                                                 input int unsigned lo, input int unsigned hi);
    if (32'(v) < lo) return LEN_W'(lo);
    if (32'(v) > hi) return LEN_W'(hi);
    return v;
  endfunction

  seq_state_e       state_q, state_d;
  vid_tbl_e         tbl_q, tbl_d;
  logic             run;
  logic             r_start, r_done, t_load, t_exp;
  logic [REF_W-1:0] r_from, r_to, vid_code;
  logic [LEN_W-1:0] r_len, t_len;

  assign run = out_en_i & vtt_pgood_i;

  vrseq_vid_decode #(
    .VID_W(VID_W), .REF_W(REF_W), .FULL_CODE(FULL_CODE)
  ) u_dec (
    .tbl_i(tbl_q), .vid_i(vid_i), .code_o(vid_code)
  );

  vrseq_ramp #(.REF_W(REF_W), .LEN_W(LEN_W)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!run), .start_i(r_start),
    .from_i(r_from), .to_i(r_to), .len_i(r_len), .tick_i(tick_us_i),
    .ref_o(ref_code_o), .done_o(r_done)
  );

  // One timer serves both settle windows; they never overlap
  vrseq_tick_timer #(.CNT_W(LEN_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!run), .load_i(t_load),
    .len_i(t_len), .tick_i(tick_us_i), .expired_o(t_exp)
  );

  always_comb begin
    state_d = state_q;
    tbl_d   = tbl_q;
    r_start = 1'b0;
    r_from  = '0;
    r_to    = BOOT_CODE;
    r_len   = clamp_len(boot_ramp_us_i, BOOT_LEN_MIN, BOOT_LEN_MAX);
    t_load  = 1'b0;
    t_len   = LEN_W'(VID_WAIT_US);
    if (!run) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          r_start = 1'b1;
          tbl_d   = vid_tbl_e'(tbl_sel_i);
          state_d = ST_BOOT_RAMP;
        end
        ST_BOOT_RAMP: if (r_done) begin
          t_load  = 1'b1;
          state_d = ST_BOOT_HOLD;
        end
        ST_BOOT_HOLD: if (t_exp) begin
          r_start = 1'b1;
          r_from  = BOOT_CODE;
          r_to    = vid_code;
          r_len   = clamp_len(final_ramp_us_i, FINAL_LEN_MIN, FINAL_LEN_MAX);
          state_d = ST_FINAL_RAMP;
        end
        ST_FINAL_RAMP: if (r_done) begin
          t_load  = 1'b1;
          t_len   = LEN_W'(READY_DLY_US);
          state_d = ST_READY_WAIT;
        end
        ST_READY_WAIT: if (t_exp) state_d = ST_READY;
        ST_READY: ;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tbl_q   <= TBL_EXT7;
    end else begin
      state_q <= state_d;
      tbl_q   <= tbl_d;
    end
  end

  // Combinational gate so loss of enable or rail drops ready without a register delay
  assign ready_o = run & (state_q == ST_READY);
endmodule

// File: rtl/vrseq_ctrl_chk.sv
module vrseq_ctrl_chk
  import vrseq_pkg::*;
#(
  parameter int unsigned REF_W     = 9,
  parameter int unsigned BOOT_CODE = 176,
  parameter int unsigned FULL_CODE = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_us_i,
  input logic             out_en_i,
  input logic             vtt_pgood_i,
  input logic [REF_W-1:0] ref_code_o,
  input logic             ready_o,
  input seq_state_e       state_q
);
  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_en_i && vtt_pgood_i) |=> (ref_code_o == '0) && !ready_o); // R10

  AST_REF_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ref_code_o) <= FULL_CODE); // R6

  AST_REF_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && vtt_pgood_i && !tick_us_i) |=> $stable(ref_code_o)); // R11

  AST_HOLD_AT_BOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOOT_HOLD) |-> (32'(ref_code_o) == BOOT_CODE)); // R4

  AST_READY_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(state_q) == ST_READY_WAIT)); // R9

  AST_READY_REF_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $stable(ref_code_o)); // R9
endmodule

bind vrseq_ctrl vrseq_ctrl_chk #(
  .REF_W(REF_W), .BOOT_CODE(BOOT_UV / LSB_UV), .FULL_CODE(TOP_UV / LSB_UV)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_us_i(tick_us_i), .out_en_i(out_en_i),
  .vtt_pgood_i(vtt_pgood_i), .ref_code_o(ref_code_o), .ready_o(ready_o),
  .state_q(state_q)
);

// File: tb/vrseq_ctrl_tb_top.sv
module vrseq_ctrl_tb_top;
  localparam int BOOT = 176;
  localparam int HOLD = 50;
  localparam int RDLY = 50;

  typedef struct {
    int    nb;
    int    nf;
    int    tgt;
    bit    full;
    string tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n, tick_us, pgood, out_en, tbl;
  logic [7:0]  vid;
  logic [13:0] boot_len, fin_len;
  logic [8:0]  ref_o;
  logic        ready;

  int n_chk = 0;
  int n_bad = 0;
  exp_item_t exp_q[$];

  always #2 clk = ~clk;

  vrseq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick_us), .vtt_pgood_i(pgood),
    .out_en_i(out_en), .tbl_sel_i(tbl), .vid_i(vid), .boot_ramp_us_i(boot_len),
    .final_ramp_us_i(fin_len), .ref_code_o(ref_o), .ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Target per R5 and R6
  function automatic int decode(input bit t, input logic [7:0] v);
    int k;
    if (!t) begin
      k = int'(v[6:0]);
      return (k <= 123) ? 256 - k : 0;
    end
    k = int'(v);
    return (k >= 1 && k <= 253) ? 257 - k : 0;
  endfunction

  // Reference profile per R2, R4, R8
  function automatic int exp_ref(input exp_item_t it, input int t);
    int k;
    if (t <= it.nb) return (t * BOOT) / it.nb;
    if (t <= it.nb + HOLD) return BOOT;
    if (t <= it.nb + HOLD + it.nf) begin
      k = t - it.nb - HOLD;
      if (it.tgt >= BOOT) return BOOT + (k * (it.tgt - BOOT)) / it.nf;
      return BOOT - (k * (BOOT - it.tgt)) / it.nf;
    end
    return it.tgt;
  endfunction

  // Tick generator: one-clock pulse every four clocks
  initial begin
    tick_us = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
    end
  end

  // Monitor: pops an expected item at each sequence start and tracks it tick by tick
  exp_item_t cur;
  bit mon_on = 1'b0, prof_bad, prof_done, rdy_seen;
  int t_cnt, e_ref;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        mon_on = 1'b0;
      end else if (mon_on && !(out_en && pgood)) begin
        if (!prof_done) begin n_chk++; prof_done = 1'b1; end
        if (cur.full && !rdy_seen) check(1'b0, {cur.tag, " R9 ready missing"}, 0, 1);
        mon_on = 1'b0;
      end else begin
        if (!mon_on && out_en && pgood) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 scoreboard empty at start", 0, 1);
          end else begin
            cur = exp_q.pop_front();
            mon_on = 1'b1; t_cnt = 0;
            prof_bad = 1'b0; prof_done = 1'b0; rdy_seen = 1'b0;
          end
        end else if (mon_on && tick_us) begin
          t_cnt++;
        end
        if (mon_on) begin
          e_ref = exp_ref(cur, t_cnt);
          if (int'(ref_o) != e_ref && !prof_bad) begin
            prof_bad = 1'b1;
            n_bad++;
            $display("FAIL R2 R8 %s profile at tick %0d act=%0d exp=%0d", cur.tag, t_cnt, ref_o, e_ref);
          end
          if (ready && !rdy_seen) begin
            rdy_seen = 1'b1;
            check(t_cnt == cur.nb + HOLD + cur.nf + RDLY, {cur.tag, " R9 ready tick"},
                  t_cnt, cur.nb + HOLD + cur.nf + RDLY);
            check(int'(ref_o) == cur.tgt, {cur.tag, " final level"}, ref_o, cur.tgt);
            if (!prof_done) begin n_chk++; prof_done = 1'b1; end
          end
        end
      end
    end
  end

  // Driver: one full power-up, then a shutdown through enable or power-good
  task automatic run_seq(input int nb_raw, input int nf_raw, input bit t0, input bit flip,
                         input logic [7:0] v, input bit drop_pg, input string tag);
    exp_item_t it;
    it.nb = clampi(nb_raw, 50, 10000);
    it.nf = clampi(nf_raw, 1, 2500);
    it.tgt = decode(t0, v);
    it.full = 1'b1;
    it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    boot_len = 14'(nb_raw); fin_len = 14'(nf_raw);
    tbl = t0; vid = 8'h33; out_en = 1'b1;
    while (ref_o != 9'd176) @(negedge clk);
    @(negedge clk);
    vid = v;                 // R4: only this value may be sampled
    if (flip) tbl = ~t0;     // R7: late change must be ignored
    while (!ready) @(negedge clk);
    vid = 8'h33;
    repeat (12) @(negedge clk);
    check(int'(ref_o) == it.tgt && ready, {tag, " R4 vid after sample ignored"}, ref_o, it.tgt);
    if (drop_pg) pgood = 1'b0; else out_en = 1'b0;
    #1;
    check(!ready, {tag, " R10 ready same-cycle drop"}, ready, 0);
    @(negedge clk);
    check(ref_o == 9'd0 && !ready, {tag, " R10 ref cleared"}, ref_o, 0);
    out_en = 1'b0; pgood = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; out_en = 1'b0; pgood = 1'b0; tbl = 1'b0; vid = '0;
    boot_len = 14'd500; fin_len = 14'd250;
    repeat (5) @(negedge clk);
    check(ref_o == 9'd0 && !ready, "R1 reset state", ref_o, 0);
    rst_n = 1'b1;
    // R1: enable without termination power-good stays off
    out_en = 1'b1;
    repeat (40) @(negedge clk);
    check(ref_o == 9'd0 && !ready, "R1 off without power-good", ref_o, 0);
    out_en = 1'b0; pgood = 1'b1;
    @(negedge clk);

    run_seq(500, 250, 1'b0, 1'b0, 8'hA0, 1'b0, "R5 bit7 ignored");
    run_seq(20, 100, 1'b1, 1'b1, 8'h61, 1'b0, "R3 R6 R7 down");
    run_seq(60, 0, 1'b1, 1'b0, 8'h51, 1'b0, "R3 R8 flat");
    run_seq(70, 3000, 1'b0, 1'b0, 8'hFC, 1'b0, "R3 R5 off code");
    run_seq(80, 40, 1'b1, 1'b0, 8'h01, 1'b1, "R6 R8 top code");
    run_seq(50, 7, 1'b0, 1'b0, 8'h7B, 1'b0, "R5 R8 lowest code");

    // R10: abort in the middle of the final ramp, then restart from zero
    begin
      exp_item_t it;
      it.nb = 50; it.nf = 200; it.tgt = decode(1'b0, 8'h10); it.full = 1'b0; it.tag = "R10 abort";
      exp_q.push_back(it);
      @(negedge clk);
      boot_len = 14'd50; fin_len = 14'd200; tbl = 1'b0; vid = 8'h33; out_en = 1'b1;
      while (ref_o != 9'd176) @(negedge clk);
      @(negedge clk);
      vid = 8'h10;
      while (ref_o <= 9'd176) @(negedge clk);
      out_en = 1'b0;
      #1;
      check(!ready, "R10 abort ready low", ready, 0);
      @(negedge clk);
      check(ref_o == 9'd0, "R10 abort ref cleared", ref_o, 0);
      repeat (3) @(negedge clk);
    end
    run_seq(55, 30, 1'b1, 1'b0, 8'h31, 1'b0, "R10 restart");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule